// File: doc/BRIEF.md
# Prioritized Two-Bank Interrupt Controller

This controller collects 64 interrupt sources into two banks of 32 and drives two request lines toward a processor. The fast line serves urgent work and the normal line serves everything else. Each source has a 3-bit priority. Priority values 0 and 1 route the source to the fast line and values 2 to 7 route it to the normal line. Among competing sources the smallest priority value wins, and a tie goes to the lower source number. Both lines carry the winning source number, so the handler knows which source to service without scanning.

Software reaches the block through a simple register bus with a one-cycle read latency. It can see pending requests, split by class, and acknowledge them by writing ones. It can also set per-source enables, a control word, an entry-address base and the packed priority table. A read-only entry register returns the base plus four times the overall winner, so it can index a handler table directly.

A request is captured on the rising edge of its source input. It stays pending until software acknowledges it, whatever the enable state. A control bit selects whether disabling a source removes it from the outputs at once, or whether a request that has already been admitted stays until it is acknowledged.

Top module: `irq_prio_ctrl`

## Requirements
- R1: A rising edge on a source input latches that source as pending. The request stays pending until it is acknowledged, whatever its enable bit. A source input that is held high after an acknowledge does not set the request again.
- R2: Writing a 1 to a bit of either pending view of a bank acknowledges that source and clears it. Zero bits leave their sources unchanged, and writing all ones clears the whole bank. Source n uses bank n/32 at bit n mod 32.
- R3: The fast pending view (bank 0 at 0x00, bank 1 at 0x04) shows the pending sources whose priority is 0 or 1. The normal pending view (bank 0 at 0x08, bank 1 at 0x0C) shows the pending sources whose priority is 2 to 7.
- R4: The enable registers (bank 0 at 0x18, bank 1 at 0x1C) reset to 0. An enable bit of 0 keeps its source off both outputs, and a 1 lets it through.
- R5: Priority register k (address 0x30+4k) holds sources 8k to 8k+7, with source 8k+s in bits [4s+3:4s]. Only the low 3 bits of each slot are stored, and bit 3 of a slot reads as 0. Every priority resets to 7.
- R6: An active source with priority 0 or 1 asserts the fast output, and one with priority 2 to 7 asserts the normal output. Each output carries the number of its winning source.
- R7: Within a class the smallest priority value wins, and a tie goes to the lower source number.
- R8: With control bit 0 clear (address 0x20), clearing an enable bit drops its source from the outputs and from the entry value.
- R9: With control bit 0 set, a pending source that has been seen enabled stays on the outputs after it is disabled, until it is acknowledged.
- R10: The entry register (read-only, 0x28) returns the base (0x24) plus 4 times the overall winner: the fast winner if there is one, otherwise the normal winner. It returns the base alone when neither output is asserted.
- R11: The outputs are registered. For an enabled source, the output changes on the second rising clock edge after the input edge is sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_i | input | 64 | Interrupt source inputs |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 8 | Register byte address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid the cycle after reg_rd |
| fiq_o | output | 1 | Fast interrupt request |
| fiq_id_o | output | 6 | Winning fast source number |
| irq_o | output | 1 | Normal interrupt request |
| irq_id_o | output | 6 | Winning normal source number |

## Verification
On every cycle, the assertions check three things. A sampled rising edge sets the request. A request stays pending until a clear bit hits it. Each arbiter winner is an active source of its own class. Another assertion checks that with all enables off and control bit 0 clear, neither output is asserted. Priority ordering, tie-breaking by source number, hold mode, the split pending views and the entry arithmetic are shown only by the bench. It drives directed scenarios and seeded random traffic and compares the results against its own reference model.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  localparam int BANK_W = 32;
  localparam int PRIO_W = 3;
  localparam int SLOT_W = 4;
  localparam int SLOTS_PER_REG = 8;
  typedef logic [PRIO_W-1:0] prio_t;
  localparam prio_t FAST_LIMIT = 3'd2;
  localparam prio_t PRIO_RESET = 3'd7;

  function automatic logic in_class(input prio_t p, input logic fast);
    return fast ? (p < FAST_LIMIT) : (p >= FAST_LIMIT);
  endfunction
endpackage

// File: rtl/irqc_latch.sv
module irqc_latch #(
  parameter int NSRC = 64
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NSRC-1:0] src_i,
  input  logic [NSRC-1:0] clr_i,
  input  logic [NSRC-1:0] en_i,
  input  logic            hold_i,
  output logic [NSRC-1:0] pend_o,
  output logic [NSRC-1:0] act_o
);
  logic [NSRC-1:0] prev_q, pend_q, armed_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_q  <= '0;
      pend_q  <= '0;
      armed_q <= '0;
    end else begin
      prev_q  <= src_i;
      pend_q  <= (pend_q & ~clr_i) | (src_i & ~prev_q);
      armed_q <= (armed_q | (pend_q & en_i)) & ~clr_i;
    end
  end

  assign pend_o = pend_q;
  assign act_o  = pend_q & (hold_i ? (en_i | armed_q) : en_i);

  for (genvar i = 0; i < NSRC; i++) begin : g_chk
    // R1: a sampled rising edge sets the request
    p_edge_sets_r1: assert property (@(posedge clk) disable iff (rst)
      (src_i[i] && !prev_q[i]) |=> pend_q[i]);
    // R1, R2: only a clear bit removes a request
    p_pend_holds_r1: assert property (@(posedge clk) disable iff (rst)
      (pend_q[i] && !clr_i[i]) |=> pend_q[i]);
  end
endmodule

// File: rtl/irqc_arbiter.sv
module irqc_arbiter
  import irqc_pkg::*;
#(
  parameter int NSRC = 64,
  parameter bit FAST = 1'b1,
  localparam int IDW = $clog2(NSRC)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [NSRC-1:0]     act_i,
  input  prio_t [NSRC-1:0]    prio_i,
  output logic                win_v,
  output logic [IDW-1:0]      win_idx
);
  prio_t best_p;

  always_comb begin
    win_v   = 1'b0;
    win_idx = '0;
    best_p  = '1;
    for (int i = NSRC - 1; i >= 0; i--) begin
      if (act_i[i] && in_class(prio_i[i], FAST) && (!win_v || prio_i[i] <= best_p)) begin
        win_v   = 1'b1;
        win_idx = IDW'(i);
        best_p  = prio_i[i];
      end
    end
  end

  // R6: a winner is always an active source of this class
  p_winner_valid_r6: assert property (@(posedge clk) disable iff (rst)
    win_v |-> (act_i[win_idx] && in_class(prio_i[win_idx], FAST)));
endmodule

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl
  import irqc_pkg::*;
#(
  parameter int NSRC = 64,
  parameter int AW   = 8,
  localparam int IDW   = $clog2(NSRC),
  localparam int NBANK = NSRC / BANK_W,
  localparam int NPRI  = NSRC / SLOTS_PER_REG
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NSRC-1:0] src_i,
  input  logic            reg_wr,
  input  logic            reg_rd,
  input  logic [AW-1:0]   reg_addr,
  input  logic [31:0]     reg_wdata,
  output logic [31:0]     reg_rdata,
  output logic            fiq_o,
  output logic [IDW-1:0]  fiq_id_o,
  output logic            irq_o,
  output logic [IDW-1:0]  irq_id_o
);
  localparam int OFF_PF  = 'h00;
  localparam int OFF_PN  = 'h08;
  localparam int OFF_EN  = 'h18;
  localparam int OFF_CTL = 'h20;
  localparam int OFF_BAS = 'h24;
  localparam int OFF_ENT = 'h28;
  localparam int OFF_PRI = 'h30;

  logic [NSRC-1:0] en_q, clr, pend, act, fast_mask;
  prio_t [NSRC-1:0] prio_q;
  logic            hold_q;
  logic [31:0]     base_q, entry, rd_mux;
  logic [1:0]           win_v;
  logic [1:0][IDW-1:0]  win_idx;

  always_comb begin
    clr = '0;
    if (reg_wr) begin
      for (int b = 0; b < NBANK; b++) begin
        if (reg_addr == AW'(OFF_PF + 4*b) || reg_addr == AW'(OFF_PN + 4*b))
          clr[b*BANK_W +: BANK_W] = reg_wdata;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q   <= '0;
      hold_q <= 1'b0;
      base_q <= '0;
      for (int i = 0; i < NSRC; i++) prio_q[i] <= PRIO_RESET;
    end else if (reg_wr) begin
      for (int b = 0; b < NBANK; b++)
        if (reg_addr == AW'(OFF_EN + 4*b)) en_q[b*BANK_W +: BANK_W] <= reg_wdata;
      if (reg_addr == AW'(OFF_CTL)) hold_q <= reg_wdata[0];
      if (reg_addr == AW'(OFF_BAS)) base_q <= reg_wdata;
      for (int k = 0; k < NPRI; k++)
        if (reg_addr == AW'(OFF_PRI + 4*k))
          for (int s = 0; s < SLOTS_PER_REG; s++)
            prio_q[k*SLOTS_PER_REG + s] <= reg_wdata[s*SLOT_W +: PRIO_W];
    end
  end

  irqc_latch #(.NSRC(NSRC)) u_latch (
    .clk(clk), .rst(rst), .src_i(src_i), .clr_i(clr), .en_i(en_q),
    .hold_i(hold_q), .pend_o(pend), .act_o(act)
  );

  for (genvar c = 0; c < 2; c++) begin : g_arb
    irqc_arbiter #(.NSRC(NSRC), .FAST(c == 0)) u_arb (
      .clk(clk), .rst(rst), .act_i(act), .prio_i(prio_q),
      .win_v(win_v[c]), .win_idx(win_idx[c])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      fiq_o    <= 1'b0;
      fiq_id_o <= '0;
      irq_o    <= 1'b0;
      irq_id_o <= '0;
    end else begin
      fiq_o    <= win_v[0];
      fiq_id_o <= win_idx[0];
      irq_o    <= win_v[1];
      irq_id_o <= win_idx[1];
    end
  end

  always_comb begin
    for (int i = 0; i < NSRC; i++) fast_mask[i] = in_class(prio_q[i], 1'b1);
    if (fiq_o)
      entry = base_q + {{(32-IDW-2){1'b0}}, fiq_id_o, 2'b00};
    else if (irq_o)
      entry = base_q + {{(32-IDW-2){1'b0}}, irq_id_o, 2'b00};
    else
      entry = base_q;
  end

  always_comb begin
    rd_mux = '0;
    for (int b = 0; b < NBANK; b++) begin
      if (reg_addr == AW'(OFF_PF + 4*b)) rd_mux = pend[b*BANK_W +: BANK_W] & fast_mask[b*BANK_W +: BANK_W];
      if (reg_addr == AW'(OFF_PN + 4*b)) rd_mux = pend[b*BANK_W +: BANK_W] & ~fast_mask[b*BANK_W +: BANK_W];
      if (reg_addr == AW'(OFF_EN + 4*b)) rd_mux = en_q[b*BANK_W +: BANK_W];
    end
    if (reg_addr == AW'(OFF_CTL)) rd_mux = {31'b0, hold_q};
    if (reg_addr == AW'(OFF_BAS)) rd_mux = base_q;
    if (reg_addr == AW'(OFF_ENT)) rd_mux = entry;
    for (int k = 0; k < NPRI; k++)
      if (reg_addr == AW'(OFF_PRI + 4*k))
        for (int s = 0; s < SLOTS_PER_REG; s++)
          rd_mux[s*SLOT_W +: SLOT_W] = {1'b0, prio_q[k*SLOTS_PER_REG + s]};
  end

  always_ff @(posedge clk) begin
    if (rst) reg_rdata <= '0;
    else if (reg_rd) reg_rdata <= rd_mux;
  end

  // R4, R8: with every enable off and no hold, nothing reaches the outputs
  p_masked_quiet_r8: assert property (@(posedge clk) disable iff (rst)
    ($past(en_q) == '0 && !$past(hold_q)) |-> (!fiq_o && !irq_o));
endmodule

// File: tb/test_irq_prio_ctrl.sv
module test_irq_prio_ctrl;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [63:0] src_i = '0;
  logic        reg_wr = 1'b0, reg_rd = 1'b0;
  logic [7:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        fiq_o, irq_o;
  logic [5:0]  fiq_id_o, irq_id_o;

  irq_prio_ctrl i_irq_prio_ctrl (
    .clk(clk), .rst(rst), .src_i(src_i), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .fiq_o(fiq_o), .fiq_id_o(fiq_id_o), .irq_o(irq_o), .irq_id_o(irq_id_o)
  );

  always #5 clk = ~clk;

  int checks = 0, errors = 0;
  bit done = 0;
  bit m_pend[64], m_en[64], m_armed[64];
  int m_pri[64];
  bit m_hold;
  logic [31:0] m_base;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic settle();
    repeat (3) @(negedge clk);
    for (int i = 0; i < 64; i++) if (m_pend[i] && m_en[i]) m_armed[i] = 1;
  endtask

  task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 0;
    for (int b = 0; b < 2; b++) begin
      if (a == 8'(4*b) || a == 8'(8 + 4*b))
        for (int j = 0; j < 32; j++) if (d[j]) begin m_pend[32*b+j] = 0; m_armed[32*b+j] = 0; end
      if (a == 8'(8'h18 + 4*b)) for (int j = 0; j < 32; j++) m_en[32*b+j] = d[j];
    end
    if (a == 8'h20) m_hold = d[0];
    if (a == 8'h24) m_base = d;
    for (int k = 0; k < 8; k++)
      if (a == 8'(8'h30 + 4*k)) for (int s = 0; s < 8; s++) m_pri[8*k+s] = int'(d[4*s +: 3]);
    settle();
  endtask

  task automatic bus_read(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_rd = 1; reg_addr = a;
    @(negedge clk);
    reg_rd = 0;
    d = reg_rdata;
  endtask

  task automatic drive_src(input logic [63:0] v, input bit wait_settle);
    @(negedge clk);
    for (int i = 0; i < 64; i++) if (v[i] && !src_i[i]) m_pend[i] = 1;
    src_i = v;
    if (wait_settle) settle();
  endtask

  function automatic bit m_act(input int i);
    return m_pend[i] && (m_en[i] || (m_hold && m_armed[i]));
  endfunction

  task automatic exp_win(input bit fast, output bit v, output int idx);
    int bp;
    v = 0; idx = 0; bp = 8;
    for (int i = 0; i < 64; i++)
      if (m_act(i) && ((m_pri[i] < 2) == fast) && m_pri[i] < bp) begin
        v = 1; idx = i; bp = m_pri[i];
      end
  endtask

  task automatic check_all(input string req);
    bit fv, nv;
    int fi, ni;
    logic [31:0] d, e;
    exp_win(1, fv, fi);
    exp_win(0, nv, ni);
    chk({req, " fast line"}, 32'(fiq_o), 32'(fv));
    if (fv) chk({req, " fast id"}, 32'(fiq_id_o), 32'(fi));
    chk({req, " normal line"}, 32'(irq_o), 32'(nv));
    if (nv) chk({req, " normal id"}, 32'(irq_id_o), 32'(ni));
    e = fv ? m_base + 32'(fi * 4) : (nv ? m_base + 32'(ni * 4) : m_base);
    bus_read(8'h28, d);
    chk({req, " R10 entry"}, d, e);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=running expected=finished");
    finish_run();
  end

  initial begin
    logic [31:0] d;
    logic [63:0] v;
    void'($urandom(32'd4711));
    for (int i = 0; i < 64; i++) begin m_pend[i] = 0; m_en[i] = 0; m_armed[i] = 0; m_pri[i] = 7; end
    m_hold = 0; m_base = 0;
    repeat (4) @(negedge clk);
    rst = 0;
    @(negedge clk);

    // reset state
    chk("R11 reset fast", 32'(fiq_o), 0);
    chk("R11 reset normal", 32'(irq_o), 0);
    bus_read(8'h18, d); chk("R4 enable0 reset", d, 0);
    bus_read(8'h1C, d); chk("R4 enable1 reset", d, 0);
    bus_read(8'h34, d); chk("R5 priority reset", d, 32'h7777_7777);

    // R4: an enabled-off source does not show
    drive_src(64'h1 << 2, 1);
    check_all("R4 masked");
    bus_read(8'h08, d); chk("R1 pending while masked", d, 32'h4);
    bus_write(8'h08, 32'hFFFF_FFFF);

    // R11 latency
    bus_write(8'h18, 32'hFFFF_FFFF);
    bus_write(8'h1C, 32'hFFFF_FFFF);
    @(negedge clk);
    for (int i = 0; i < 64; i++) if (i == 5 && !src_i[i]) m_pend[i] = 1;
    src_i[5] = 1;
    @(negedge clk);
    chk("R11 not yet", 32'(irq_o), 0);
    @(negedge clk);
    chk("R11 after two edges", 32'(irq_o), 1);
    chk("R11 id", 32'(irq_id_o), 5);
    settle();
    check_all("R6 normal");

    // R5 and R6: priority slot bit 3 dropped, source 40 becomes fast
    bus_write(8'h44, 32'h7777_7778);
    bus_read(8'h44, d); chk("R5 slot readback", d, 32'h7777_7770);
    drive_src(src_i | (64'h1 << 40), 1);
    check_all("R6 fast");
    chk("R6 fast id 40", 32'(fiq_id_o), 40);

    // R7 tie and lower value
    drive_src(src_i | (64'h1 << 3), 1);
    chk("R7 tie lower number", 32'(irq_id_o), 3);
    bus_write(8'h34, 32'h7777_7277);
    drive_src(src_i | (64'h1 << 10), 1);
    chk("R7 lower value wins", 32'(irq_id_o), 10);
    check_all("R7");

    // R3 pending views
    bus_read(8'h04, d); chk("R3 fast view bank1", d, 32'h100);
    bus_read(8'h00, d); chk("R3 fast view bank0", d, 0);
    bus_read(8'h08, d); chk("R3 normal view bank0", d, 32'h428);
    bus_read(8'h0C, d); chk("R3 normal view bank1", d, 0);

    // R2 clears; R1 held levels do not re-latch
    bus_write(8'h04, 32'h100);
    check_all("R2 single clear");
    bus_write(8'h08, 32'hFFFF_FFFF);
    bus_read(8'h08, d); chk("R2 all ones clear", d, 0);
    check_all("R1 no relatch");

    // R8 mask drops immediately
    drive_src(src_i | (64'h1 << 20), 1);
    check_all("R8 before mask");
    bus_write(8'h18, 32'h0);
    check_all("R8 after mask");
    chk("R8 normal off", 32'(irq_o), 0);
    bus_read(8'h08, d); chk("R1 still pending", d, 32'h10_0000);

    // R9 hold mode
    bus_write(8'h20, 32'h1);
    bus_write(8'h18, 32'hFFFF_FFFF);
    bus_write(8'h18, 32'h0);
    chk("R9 held after disable", 32'(irq_o), 1);
    chk("R9 held id", 32'(irq_id_o), 20);
    bus_write(8'h08, 32'h10_0000);
    chk("R9 drops on clear", 32'(irq_o), 0);
    bus_write(8'h20, 32'h0);

    // R10 base
    bus_write(8'h24, 32'h0000_1000);
    check_all("R10 empty");
    bus_write(8'h18, 32'hFFFF_FFFF);
    drive_src(64'h0, 1);
    drive_src(64'h1 << 7, 1);
    check_all("R10 with winner");

    // random traffic
    for (int it = 0; it < 400; it++) begin
      case ($urandom % 6)
        0, 1: begin v = {$urandom, $urandom} & {$urandom, $urandom}; drive_src(v, 1); end
        2: bus_write(8'(8'h18 + 4 * ($urandom % 2)), $urandom | $urandom);
        3: bus_write(8'(8'h30 + 4 * ($urandom % 8)), $urandom);
        4: bus_write(8'(4 * ($urandom % 4)), $urandom & $urandom);
        default: bus_write(($urandom % 2) ? 8'h20 : 8'h24, $urandom);
      endcase
      check_all("R6 R7 R9 random");
    end
    finish_run();
  end
endmodule